// File: doc/BRIEF.md
# Serial Bank Register Loader with Write Lockout

This block is the processor-facing write side of a cartridge bank controller. The processor changes a bank register one bit at a time. Each write carries one data bit, and five accepted writes fill a 5-bit shift path. On the fifth write, the collected value moves into one of four bank registers. A write that has data bit 7 set restarts the sequence instead of shifting.

Read-modify-write instructions put two writes on consecutive cycles. A short lockout window filters them, so only the first write counts. The block also turns the program bank register and the processor address bit 14 into the program ROM bank number for the current access. It handles both the 32 KiB banking arrangement and the two 16 KiB arrangements.

The write port is a plain strobe and has no back-pressure. A write that arrives during the lockout window is discarded without notice. The processor must not assume that it was taken. Bits 0 and 7 of the processor data byte arrive as two separate pins, because the block uses no other bit.

Top module: `bank_serial_port`

## Requirements
- R1: A write that is accepted loads a lockout counter with 2. Write strobes on the next two clock edges are discarded, and a strobe on the third edge after an accepted write is accepted.
- R2: A discarded write changes neither the shift count, nor the shift bits, nor any bank register, whatever its data. It does not reload the lockout counter.
- R3: An accepted write with the restart bit (data bit 7) set clears the shift count and the shift bits to 0. It sets control bit 3 (the 16 KiB size mode) to 1, leaves the other control bits as they are, and changes no other register.
- R4: An accepted write with the restart bit clear shifts the serial bit (data bit 0) into shift bit 4, moves the other shift bits down by one, and adds one to the shift count.
- R5: The fifth accepted shifting write commits the 5-bit value to the register chosen by `wr_target`, with the first bit written as the value's bit 0. The targets are 0 control, 1 first picture bank, 2 second picture bank, and 3 program bank. For target 3, bits 3:0 are the bank and bit 4 is `ram_off`. The shift count and shift bits return to 0 on that write.
- R6: Reset clears the lockout counter, the shift count, the shift bits, both picture banks, the program bank and `ram_off`. It sets the control register to 5'b01100.
- R7: When control bit 3 is 0 (32 KiB mode), `prg_bank_sel` is the program bank with bit 0 replaced by `rd_a14`.
- R8: When control bit 3 is 1 and control bit 2 is 1, `prg_bank_sel` is the program bank if `rd_a14` is 0 and all ones if `rd_a14` is 1.
- R9: When control bit 3 is 1 and control bit 2 is 0, `prg_bank_sel` is 0 if `rd_a14` is 0 and the program bank if `rd_a14` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle per processor write |
| wr_target | input | 2 | Processor address bits 14:13, which pick the register |
| wr_bit | input | 1 | Data bit 0, the serial bit |
| wr_restart | input | 1 | Data bit 7, which restarts the shift sequence |
| rd_a14 | input | 1 | Processor address bit 14 of the current program access |
| shift_count | output | 3 | Number of bits collected so far |
| shift_bits | output | 5 | Shift path contents |
| ctrl_reg | output | 5 | Control register |
| chr_bank0 | output | 5 | First picture bank register |
| chr_bank1 | output | 5 | Second picture bank register |
| prg_bank | output | 4 | Program bank register |
| ram_off | output | 1 | Work RAM disable bit |
| prg_bank_sel | output | 4 | Program ROM bank for the current access |

## Verification
Every register result appears one clock edge after the write that causes it. The bench raises stimulus on a falling edge and samples on the next falling edge, after a single rising edge. `prg_bank_sel` is combinational from the registers and `rd_a14`, so it is sampled on the same falling edge as a register change, or after `rd_a14` settles.

The lockout checks hold the strobe high over four successive rising edges and sample after each one. This confirms that the first and fourth edges take the write and the middle two do not. Serial loads leave two idle edges after each write, so that each write falls outside the lockout window of the write before it.

// File: rtl/bank_serial_pkg.sv
package bank_serial_pkg;
  localparam int SHIFT_W     = 5;
  localparam int LOCK_CYCLES = 2;
  localparam int PRG_W       = SHIFT_W - 1;
  localparam int CNT_W       = $clog2(SHIFT_W + 1);
  localparam int LOCK_W      = $clog2(LOCK_CYCLES + 1);
  localparam logic [SHIFT_W-1:0] CTRL_RESET = 5'b01100;
  localparam int SIZE_BIT    = 3;
  localparam int SLOT_BIT    = 2;

  typedef enum logic [1:0] {
    TGT_CTRL = 2'd0,
    TGT_CHR0 = 2'd1,
    TGT_CHR1 = 2'd2,
    TGT_PRG  = 2'd3
  } target_e;
endpackage

// File: rtl/wr_lockout.sv
module wr_lockout
  import bank_serial_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  output logic accept,
  output logic busy
);
  logic [LOCK_W-1:0] lock_q;

  assign busy   = (lock_q != '0);
  assign accept = wr_en && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lock_q <= '0;
    else if (accept) lock_q <= LOCK_W'(LOCK_CYCLES);
    else if (busy)   lock_q <= lock_q - 1'b1;
  end

  assert_lock_reload_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (lock_q == LOCK_W'(LOCK_CYCLES)));

  assert_lock_drain_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> (lock_q == $past(lock_q) - 1'b1));
endmodule

// File: rtl/serial_shifter.sv
module serial_shifter
  import bank_serial_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               accept,
  input  logic               wr_bit,
  input  logic               wr_restart,
  output logic [CNT_W-1:0]   shift_count,
  output logic [SHIFT_W-1:0] shift_bits,
  output logic               commit,
  output logic               restart,
  output logic [SHIFT_W-1:0] commit_value
);
  logic last_bit;

  assign restart      = accept && wr_restart;
  assign last_bit     = (shift_count == CNT_W'(SHIFT_W - 1));
  assign commit       = accept && !wr_restart && last_bit;
  assign commit_value = {wr_bit, shift_bits[SHIFT_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_count <= '0;
      shift_bits  <= '0;
    end else if (restart || commit) begin
      shift_count <= '0;
      shift_bits  <= '0;
    end else if (accept) begin
      shift_count <= shift_count + 1'b1;
      shift_bits  <= commit_value;
    end
  end

  assert_drop_keeps_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !accept) |=> ($stable(shift_count) && $stable(shift_bits)));

  assert_restart_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (shift_count == '0 && shift_bits == '0));

  assert_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    shift_count <= CNT_W'(SHIFT_W - 1));
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
  import bank_serial_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit,
  input  logic               restart,
  input  logic [1:0]         target,
  input  logic [SHIFT_W-1:0] value,
  output logic [SHIFT_W-1:0] ctrl_reg,
  output logic [SHIFT_W-1:0] chr_bank0,
  output logic [SHIFT_W-1:0] chr_bank1,
  output logic [PRG_W-1:0]   prg_bank,
  output logic               ram_off
);
  target_e tgt;
  assign tgt = target_e'(target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_reg  <= CTRL_RESET;
      chr_bank0 <= '0;
      chr_bank1 <= '0;
      prg_bank  <= '0;
      ram_off   <= 1'b0;
    end else if (restart) begin
      ctrl_reg[SIZE_BIT] <= 1'b1;
    end else if (commit) begin
      unique case (tgt)
        TGT_CTRL: ctrl_reg  <= value;
        TGT_CHR0: chr_bank0 <= value;
        TGT_CHR1: chr_bank1 <= value;
        TGT_PRG: begin
          prg_bank <= value[PRG_W-1:0];
          ram_off  <= value[SHIFT_W-1];
        end
      endcase
    end
  end

  assert_commit_prg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && tgt == TGT_PRG) |=> (prg_bank == $past(value[PRG_W-1:0])));

  assert_restart_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (ctrl_reg[SIZE_BIT] && $stable(prg_bank) && $stable(chr_bank0)));
endmodule

// File: rtl/prg_mapper.sv
module prg_mapper
  import bank_serial_pkg::*;
(
  input  logic               size_16k,
  input  logic               slot_low,
  input  logic [PRG_W-1:0]   prg_bank,
  input  logic               a14,
  output logic [PRG_W-1:0]   bank_sel
);
  always_comb begin
    if (!size_16k)     bank_sel = {prg_bank[PRG_W-1:1], a14};
    else if (slot_low) bank_sel = a14 ? '1 : prg_bank;
    else               bank_sel = a14 ? prg_bank : '0;
  end
endmodule

// File: rtl/bank_serial_port.sv
module bank_serial_port
  import bank_serial_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_target,
  input  logic               wr_bit,
  input  logic               wr_restart,
  input  logic               rd_a14,
  output logic [CNT_W-1:0]   shift_count,
  output logic [SHIFT_W-1:0] shift_bits,
  output logic [SHIFT_W-1:0] ctrl_reg,
  output logic [SHIFT_W-1:0] chr_bank0,
  output logic [SHIFT_W-1:0] chr_bank1,
  output logic [PRG_W-1:0]   prg_bank,
  output logic               ram_off,
  output logic [PRG_W-1:0]   prg_bank_sel
);
  logic               accept;
  logic               busy;
  logic               commit;
  logic               restart;
  logic [SHIFT_W-1:0] commit_value;

  wr_lockout u_lockout (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .accept (accept),
    .busy   (busy)
  );

  serial_shifter u_shifter (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .accept       (accept),
    .wr_bit       (wr_bit),
    .wr_restart   (wr_restart),
    .shift_count  (shift_count),
    .shift_bits   (shift_bits),
    .commit       (commit),
    .restart      (restart),
    .commit_value (commit_value)
  );

  bank_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit),
    .restart   (restart),
    .target    (wr_target),
    .value     (commit_value),
    .ctrl_reg  (ctrl_reg),
    .chr_bank0 (chr_bank0),
    .chr_bank1 (chr_bank1),
    .prg_bank  (prg_bank),
    .ram_off   (ram_off)
  );

  prg_mapper u_mapper (
    .size_16k (ctrl_reg[SIZE_BIT]),
    .slot_low (ctrl_reg[SLOT_BIT]),
    .prg_bank (prg_bank),
    .a14      (rd_a14),
    .bank_sel (prg_bank_sel)
  );

  assert_busy_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  assert_map_32k_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_reg[SIZE_BIT] |-> (prg_bank_sel[PRG_W-1:1] == prg_bank[PRG_W-1:1]
                             && prg_bank_sel[0] == rd_a14));

  assert_map_fixed_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_reg[SIZE_BIT] && ctrl_reg[SLOT_BIT] && rd_a14) |-> (prg_bank_sel == '1));

  assert_map_fixed_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_reg[SIZE_BIT] && !ctrl_reg[SLOT_BIT] && !rd_a14) |-> (prg_bank_sel == '0));
endmodule

// File: tb/test_bank_serial_port.sv
module test_bank_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 7;
  // {target[1:0], value[4:0], sel_a14_0[3:0], sel_a14_1[3:0]}
  localparam logic [14:0] VEC [N_VEC] = '{
    {2'd3, 5'b00101, 4'h5, 4'hF},
    {2'd0, 5'b00000, 4'h4, 4'h5},
    {2'd3, 5'b11010, 4'hA, 4'hB},
    {2'd0, 5'b01000, 4'h0, 4'hA},
    {2'd1, 5'b10011, 4'h0, 4'hA},
    {2'd2, 5'b01110, 4'h0, 4'hA},
    {2'd0, 5'b01100, 4'hA, 4'hF}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_target = 2'd0;
  logic       wr_bit = 1'b0;
  logic       wr_restart = 1'b0;
  logic       rd_a14 = 1'b0;
  logic [2:0] shift_count;
  logic [4:0] shift_bits, ctrl_reg, chr_bank0, chr_bank1;
  logic [3:0] prg_bank, prg_bank_sel;
  logic       ram_off;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_serial_port i_bank_serial_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_target(wr_target),
    .wr_bit(wr_bit), .wr_restart(wr_restart), .rd_a14(rd_a14),
    .shift_count(shift_count), .shift_bits(shift_bits), .ctrl_reg(ctrl_reg),
    .chr_bank0(chr_bank0), .chr_bank1(chr_bank1), .prg_bank(prg_bank),
    .ram_off(ram_off), .prg_bank_sel(prg_bank_sel)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] readback(input logic [1:0] tgt);
    case (tgt)
      2'd0: return ctrl_reg;
      2'd1: return chr_bank0;
      2'd2: return chr_bank1;
      default: return {ram_off, prg_bank};
    endcase
  endfunction

  // One accepted write, then two idle edges so the lockout has drained.
  task automatic wr(input logic b, input logic rs, input logic [1:0] tgt);
    wr_en = 1'b1; wr_bit = b; wr_restart = rs; wr_target = tgt;
    @(negedge clk);
    wr_en = 1'b0; wr_restart = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic load5(input logic [1:0] tgt, input logic [4:0] val);
    for (int i = 0; i < 5; i++) wr(val[i], 1'b0, tgt);
  endtask

  task automatic check_sel(input string req, input logic [3:0] e0, input logic [3:0] e1);
    rd_a14 = 1'b0; #1; chk(req, 8'(prg_bank_sel), 8'(e0));
    rd_a14 = 1'b1; #1; chk(req, 8'(prg_bank_sel), 8'(e1));
    rd_a14 = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R6: values held in reset
    chk("R6 count", 8'(shift_count), 8'd0);
    chk("R6 bits", 8'(shift_bits), 8'd0);
    chk("R6 ctrl", 8'(ctrl_reg), 8'b01100);
    chk("R6 prg", 8'(prg_bank), 8'd0);
    chk("R6 chr0", 8'(chr_bank0), 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: reset state selects 16 KiB, switchable low slot
    check_sel("R8 reset map", 4'h0, 4'hF);

    // Table walk: R5 commits, R7/R8/R9 mapping
    for (int v = 0; v < N_VEC; v++) begin
      logic [1:0] tgt;
      logic [4:0] val;
      tgt = VEC[v][14:13];
      val = VEC[v][12:8];
      load5(tgt, val);
      chk($sformatf("R5 commit vec%0d", v), 8'(readback(tgt)), 8'(val));
      chk($sformatf("R5 shift cleared vec%0d", v), 8'(shift_count), 8'd0);
      check_sel($sformatf("R7/R8/R9 map vec%0d", v), VEC[v][7:4], VEC[v][3:0]);
    end

    // R1/R2/R4: strobe held four edges: take, drop, drop, take
    wr_en = 1'b1; wr_bit = 1'b1; wr_restart = 1'b0; wr_target = 2'd0;
    @(negedge clk);
    chk("R1 first write taken", 8'(shift_count), 8'd1);
    chk("R4 bit enters top", 8'(shift_bits), 8'b10000);
    wr_restart = 1'b1;
    @(negedge clk);
    chk("R1 back-to-back dropped", 8'(shift_count), 8'd1);
    chk("R2 dropped restart ignored", 8'(shift_bits), 8'b10000);
    wr_restart = 1'b0; wr_bit = 1'b0;
    @(negedge clk);
    chk("R1 second edge dropped", 8'(shift_count), 8'd1);
    @(negedge clk);
    chk("R2 no reload, third edge taken", 8'(shift_count), 8'd2);
    chk("R4 shift down", 8'(shift_bits), 8'b01000);
    wr_en = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R2 ctrl untouched", 8'(ctrl_reg), 8'b01100);

    // R3: restart mid-sequence
    wr(1'b0, 1'b1, 2'd0);
    load5(2'd0, 5'b00011);
    chk("R5 ctrl load", 8'(ctrl_reg), 8'b00011);
    check_sel("R7 32k map", 4'hA, 4'hB);
    wr(1'b1, 1'b0, 2'd0);
    chk("R4 partial", 8'(shift_count), 8'd1);
    wr(1'b0, 1'b1, 2'd0);
    chk("R3 count cleared", 8'(shift_count), 8'd0);
    chk("R3 bits cleared", 8'(shift_bits), 8'd0);
    chk("R3 size bit set", 8'(ctrl_reg), 8'b01011);
    chk("R3 chr0 kept", 8'(chr_bank0), 8'b10011);
    check_sel("R9 map", 4'h0, 4'hA);
    load5(2'd1, 5'b00110);
    chk("R5 fresh load after restart", 8'(chr_bank0), 8'b00110);

    // R6: reset during lockout, then an immediate write is accepted
    wr_en = 1'b1; wr_bit = 1'b1; wr_target = 2'd2;
    @(negedge clk);
    wr_en = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R6 reset count", 8'(shift_count), 8'd0);
    chk("R6 reset ctrl", 8'(ctrl_reg), 8'b01100);
    chk("R6 reset prg", 8'(prg_bank), 8'd0);
    chk("R6 reset ram_off", 8'(ram_off), 8'd0);
    @(negedge clk);
    rst_n = 1'b1;
    wr_en = 1'b1; wr_bit = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R6 lockout cleared by reset", 8'(shift_count), 8'd1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule